// File: doc/BRIEF.md
# Burst-Clocked Serial Command Transmitter

This block hands a 32-bit status/command word to a remote processor over a single serial data line. The remote side paces the whole exchange. Its load strobe is active low on the line and is inverted on entry. The rising edge of the inverted strobe copies the parallel word into a shift register. The same edge starts a short clear pulse, which wipes the transmit-request flag and the test-mode flag.

The remote side then sends shift clocks, normally as two bursts of 16 pulses. Each rising edge moves the register one place, and the serial output presents the next bit. Both external strobes are brought into the system clock domain through two-flop synchronisers, and their rising edges are detected there. A bit counter reports completion after 32 shifts. Shifts that arrive after completion push out zeros and leave a sticky overrun mark.

Top module: `burst_cmd_tx`

## Requirements
- R1: While reset is active, and just after it is released, `ser_out`, `xmit_req`, `test_mode`, `clr_active`, `done` and `overrun` are all 0.
- R2: A falling edge on `load_n` captures `par_word`. Within four system clock cycles, `ser_out` shows bit 31 of the captured word.
- R3: Bits leave most significant first. Each rising edge on `shift_clk` moves `ser_out` to the next lower bit, and `ser_out` holds its value between edges.
- R4: `done` stays 0 through the first 31 shift edges after a load and becomes 1 on the 32nd.
- R5: When no clear pulse is active, a high level on `req_set` sets `xmit_req` and a high level on `test_set` sets `test_mode`. Each flag stays set after its input falls.
- R6: A load edge raises `clr_active`, which drives both flags to 0. While `clr_active` is high, it takes priority over the set inputs.
- R7: `clr_active` drops one cycle after both flags read 0. It therefore lasts two cycles when a flag was set and one cycle when both were already clear.
- R8: A shift edge that arrives while `done` is 1 leaves `ser_out` at 0 and sets `overrun`. `overrun` stays 1, even through a new load, until reset.
- R9: A load edge in the middle of a transfer reloads the register, clears `done` and restarts the count, so 32 further shifts are needed.
- R10: A pause of any length between shift bursts does not change the bit order or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| par_word | input | 32 | Parallel status/command word, sampled on a load edge |
| req_set | input | 1 | Level that sets the transmit-request flag |
| test_set | input | 1 | Level that sets the test-mode flag |
| load_n | input | 1 | Load strobe from the remote side, active low |
| shift_clk | input | 1 | Shift clock from the remote side, delivered in bursts |
| ser_out | output | 1 | Serial data, most significant bit first |
| xmit_req | output | 1 | Transmit-request flag |
| test_mode | output | 1 | Test-mode flag |
| clr_active | output | 1 | Self-ending flag-clear pulse |
| done | output | 1 | High once 32 bits have been shifted |
| overrun | output | 1 | Sticky mark for shift edges received after completion |

## Verification
The shift path is driven with three words. An alternating mixed pattern shows whether bits are reordered or skipped. A word with only its two end bits set shows whether the first and last positions are right and whether a shift is off by one. An all-ones word shows whether zeros enter the register before completion. Each word is sent as two bursts of 16 with a long gap between them, and a reload part-way through a transfer shows whether the counter really restarts. The clear logic is tried with both flags set and with both flags already clear, which separates the two-cycle pulse from the one-cycle pulse.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
  parameter int WORD_W_DEF = 32;
  parameter int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/btx_edge_sync.sv
module btx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic evt
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign evt = sync_q[STAGES-1] & ~prev_q;

  // R3: one input edge yields a single one-cycle event
  a_r3_single_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/btx_flag_clear.sv
module btx_flag_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic req_set,
  input  logic test_set,
  output logic xmit_q,
  output logic test_q,
  output logic clr_q
);
  logic xmit_d, test_d, clr_d;

  always_comb begin
    clr_d = clr_q;
    if (load_evt)
      clr_d = 1'b1;
    else if (clr_q && !xmit_q && !test_q)
      clr_d = 1'b0;

    xmit_d = xmit_q;
    test_d = test_q;
    if (clr_q) begin
      xmit_d = 1'b0;
      test_d = 1'b0;
    end else begin
      if (req_set)  xmit_d = 1'b1;
      if (test_set) test_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      xmit_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      clr_q  <= clr_d;
      xmit_q <= xmit_d;
      test_q <= test_d;
    end
  end

  // R6: an active clear leaves both flags low on the next cycle
  a_r6_clr_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (!xmit_q && !test_q));
  // R7: the clear ends once both flags read low
  a_r7_clr_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !xmit_q && !test_q && !load_evt) |=> !clr_q);
endmodule

// File: rtl/btx_shifter.sv
module btx_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic [WORD_W-1:0] par_word,
  output logic              ser_out,
  output logic              done,
  output logic              overrun
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovr_q, ovr_d;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    ovr_d  = ovr_q;
    if (load_evt) begin
      sreg_d = par_word;
      cnt_d  = '0;
    end else if (shift_evt) begin
      sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
      if (cnt_q == CNT_FULL)
        ovr_d = 1'b1;
      else
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
    end
  end

  assign ser_out = sreg_q[WORD_W-1];
  assign done    = (cnt_q == CNT_FULL);
  assign overrun = ovr_q;

  // R4: the count never passes the word width
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R8: overrun is sticky
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R8: the line is low once the word is out
  a_r8_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ser_out);
  // R9: a load restarts the count
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!done && cnt_q == '0));
endmodule

// File: rtl/burst_cmd_tx.sv
module burst_cmd_tx #(
  parameter int WORD_W      = burst_tx_pkg::WORD_W_DEF,
  parameter int SYNC_STAGES = burst_tx_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] par_word,
  input  logic              req_set,
  input  logic              test_set,
  input  logic              load_n,
  input  logic              shift_clk,
  output logic              ser_out,
  output logic              xmit_req,
  output logic              test_mode,
  output logic              clr_active,
  output logic              done,
  output logic              overrun
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_hi, load_evt, shift_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign load_hi = ~load_n;

  btx_edge_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(clk), .rst_n(rst_int_n), .din(load_hi), .evt(load_evt));

  btx_edge_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
    .clk(clk), .rst_n(rst_int_n), .din(shift_clk), .evt(shift_evt));

  btx_flag_clear u_flags (
    .clk(clk), .rst_n(rst_int_n), .load_evt(load_evt),
    .req_set(req_set), .test_set(test_set),
    .xmit_q(xmit_req), .test_q(test_mode), .clr_q(clr_active));

  btx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load_evt(load_evt),
    .shift_evt(shift_evt), .par_word(par_word),
    .ser_out(ser_out), .done(done), .overrun(overrun));
endmodule

// File: tb/burst_cmd_tx_tb.sv
module burst_cmd_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] par_word = '0;
  logic        req_set = 1'b0, test_set = 1'b0, load_n = 1'b1, shift_clk = 1'b0;
  logic        ser_out, xmit_req, test_mode, clr_active, done, overrun;

  int total = 0;
  int bad = 0;
  int clr_cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_cmd_tx u_dut (
    .clk(clk), .rst_n(rst_n), .par_word(par_word), .req_set(req_set),
    .test_set(test_set), .load_n(load_n), .shift_clk(shift_clk),
    .ser_out(ser_out), .xmit_req(xmit_req), .test_mode(test_mode),
    .clr_active(clr_active), .done(done), .overrun(overrun));

  always @(negedge clk) if (clr_active) clr_cycles++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load_n = 1'b1; shift_clk = 1'b0; req_set = 1'b0; test_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_load(input logic [31:0] w);
    par_word = w;
    @(negedge clk) load_n = 1'b0;
    repeat (4) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_shift();
    @(negedge clk) shift_clk = 1'b1;
    repeat (3) @(negedge clk);
    shift_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({ser_out, xmit_req, test_mode, clr_active, done, overrun} == 6'b0, "R1 in reset",
        {ser_out, xmit_req, test_mode, clr_active, done, overrun}, 0);
    do_reset();
    chk({ser_out, xmit_req, test_mode, clr_active, done, overrun} == 6'b0, "R1 after release",
        {ser_out, xmit_req, test_mode, clr_active, done, overrun}, 0);
  endtask

  task automatic t_flags();
    @(negedge clk) req_set = 1'b1;
    @(negedge clk) req_set = 1'b0;
    @(negedge clk);
    chk(xmit_req === 1'b1, "R5 request held", xmit_req, 1);
    chk(test_mode === 1'b0, "R5 test untouched", test_mode, 0);
    @(negedge clk) test_set = 1'b1;
    @(negedge clk) test_set = 1'b0;
    @(negedge clk);
    chk(test_mode === 1'b1, "R5 test held", test_mode, 1);
  endtask

  task automatic t_clear();
    clr_cycles = 0;
    do_load(32'h1234_5678);
    chk(!xmit_req && !test_mode, "R6 flags wiped", {xmit_req, test_mode}, 0);
    chk(clr_cycles == 2, "R7 pulse with flags set", clr_cycles, 2);
    clr_cycles = 0;
    do_load(32'h1234_5678);
    chk(clr_cycles == 1, "R7 pulse with flags clear", clr_cycles, 1);
    @(negedge clk) req_set = 1'b1;
    @(negedge clk) req_set = 1'b0;
    chk(xmit_req === 1'b1, "R5 set after clear ends", xmit_req, 1);
  endtask

  task automatic t_word(input logic [31:0] w, input int gap);
    do_load(w);
    chk(done === 1'b0, "R4 done low after load", done, 0);
    for (int i = 0; i < 32; i++) begin
      chk(ser_out === w[31-i], "R2 R3 bit order", ser_out, w[31-i]);
      do_shift();
      if (i == 15) repeat (gap) @(negedge clk);
      if (i == 15) chk(ser_out === w[15], "R10 hold across gap", ser_out, w[15]);
      if (i == 30) chk(done === 1'b0, "R4 not done after 31", done, 0);
    end
    chk(done === 1'b1, "R4 done after 32", done, 1);
    chk(ser_out === 1'b0, "R8 line low at end", ser_out, 0);
    chk(overrun === 1'b0, "R8 no overrun yet", overrun, 0);
  endtask

  task automatic t_reload();
    do_load(32'hFFFF_0000);
    for (int i = 0; i < 10; i++) do_shift();
    do_load(32'h9000_0003);
    chk(ser_out === 1'b1, "R9 new word bit31", ser_out, 1);
    chk(done === 1'b0, "R9 done cleared", done, 0);
    for (int i = 0; i < 31; i++) do_shift();
    chk(done === 1'b0, "R9 not done after 31", done, 0);
    chk(ser_out === 1'b1, "R9 last bit", ser_out, 1);
    do_shift();
    chk(done === 1'b1, "R9 done after 32", done, 1);
  endtask

  task automatic t_overrun();
    do_shift();
    chk(overrun === 1'b1, "R8 overrun set", overrun, 1);
    chk(ser_out === 1'b0, "R8 zero shifted", ser_out, 0);
    do_load(32'hFFFF_FFFF);
    chk(overrun === 1'b1, "R8 sticky over load", overrun, 1);
    do_reset();
    chk(overrun === 1'b0, "R8 cleared by reset", overrun, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flags();
    t_clear();
    t_word(32'hA5C3_0F1E, 40);
    t_word(32'h8000_0001, 7);
    t_word(32'hFFFF_FFFF, 0);
    t_reload();
    t_overrun();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule